// File: doc/BRIEF.md
# Dual-Slot TDMA Burst Sequencer

The sequencer sits behind a symbol slicer whose dibit stream is already aligned to 144-dibit burst boundaries. It walks each burst, tags every dibit with the region it belongs to (control channel header, voice frame one, the two halves of voice frame two around a 24-dibit centre field, voice frame three) and, from the centre field, tells voice-sync bursts, data-sync bursts and embedded-signalling bursts apart. The two interleaved timeslots each keep their own voice-superframe counter. It uses this counter to gate the capture of embedded link-control fragments and to flag the burst that completes a superframe.

An external Hamming decoder supplies the header check result and slot bit, and an external block-code decoder supplies the embedded-signalling check. The sequencer applies a set of lock rules to these results and to its own counters: a bad header, a bad check on a non-sync burst, a counter past its limit, too many data bursts in a row, or a frozen voice frame. When any rule fires it sets a sticky lock-lost flag, stops consuming dibits and waits for a restart pulse.

Top module: `tdma_burst_seq`

## Requirements
- R1: Each accepted dibit is echoed one clock later with a region code: 0 for positions 0-11, 1 for 12-47, 2 for 48-65, 3 for 66-89, 4 for 90-107, 5 for 108-143.
- R2: The centre field is reduced to 24 symbols, each the high bit of its dibit, first dibit in the symbol MSB. Symbols 24'h439B4D mark a voice-sync burst, 24'hBC64B2 a data-sync burst, and anything else an embedded-signalling burst. A data-sync burst is reported with burst_data_o=1 and burst_vc_o=0.
- R3: emb_bits_o holds the first 8 and the last 8 bits of the 48-bit centre field, in arrival order, MSB first. When emb_ok_i is high at the last dibit of a burst that is not a data burst, cc_o takes emb bits 15:12, pi_o takes bit 11 and lcss_o takes bits 10:9.
- R4: The slot comes from tact_slot_i at position 11. A voice burst reports vc = 1 after voice sync, and otherwise the slot's stored counter. The slot's counter then becomes vc+1. A data burst sets the slot's counter to 1. The other slot's counter is left unchanged.
- R5: At the end of the centre field, if the slot's counter is between 2 and 6, frag_we_o pulses with that counter as frag_idx_o and the 48 centre bits (first arrival in the MSB) as frag_data_o.
- R6: lc_done_o pulses with a voice burst whose reported vc is 6.
- R7: An embedded-signalling burst with emb_ok_i low drops lock. A voice-sync burst is processed even when emb_ok_i is low.
- R8: A voice burst that would raise its slot's counter above 14 drops lock.
- R9: A third data burst in a row, counted across both slots, drops lock. Any voice burst clears the run.
- R10: If the dibits at positions 1, 3, 7, 13, 16, 27, 32 and 33 of voice frame one all equal those of the previous processed burst, lock is dropped.
- R11: tact_ok_i low at position 11 drops lock at the end of that burst.
- R12: After reset or restart_i, lost_o is 0 and both counters are 2. Losing lock raises lost_o, sets both counters to 2 and produces no burst report. While lost_o is high, dibits are ignored and no strobes are produced, until restart_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| restart_i | input | 1 | Restart tracking after lock loss |
| dibit_vld_i | input | 1 | Dibit strobe |
| dibit_i | input | 2 | Received dibit |
| tact_ok_i | input | 1 | Header check result, sampled at position 11 |
| tact_slot_i | input | 1 | Timeslot bit, sampled at position 11 |
| emb_ok_i | input | 1 | Embedded-signalling check result, sampled at position 143 |
| out_vld_o | output | 1 | Echoed dibit strobe |
| out_region_o | output | 3 | Region code of echoed dibit |
| out_dibit_o | output | 2 | Echoed dibit |
| burst_vld_o | output | 1 | Burst report strobe |
| burst_slot_o | output | 1 | Slot of reported burst |
| burst_data_o | output | 1 | Reported burst was data-sync |
| burst_vc_o | output | 4 | Voice counter value of reported burst |
| lc_done_o | output | 1 | Superframe link control complete |
| emb_bits_o | output | 16 | Embedded-signalling bits |
| cc_o | output | 4 | Colour code |
| pi_o | output | 1 | Privacy indicator flag |
| lcss_o | output | 2 | Link-control start/stop field |
| frag_we_o | output | 1 | Fragment write strobe |
| frag_slot_o | output | 1 | Fragment slot |
| frag_idx_o | output | 4 | Fragment index (counter value) |
| frag_data_o | output | 48 | Fragment bits |
| cnt0_o | output | 4 | Slot 0 voice counter |
| cnt1_o | output | 4 | Slot 1 voice counter |
| lost_o | output | 1 | Sticky lock-lost flag |

## Verification
A wrong slot counter shows at the next burst of that slot. The reported vc and the counter outputs diverge at once. A fragment index or link-control pulse lands on the wrong burst within the same superframe. A wrong position count shifts the region tags on the very next dibit and corrupts the centre-field classification at the end of that burst. A faulty lock rule shows up at the end of the offending burst, either as a missing burst report with lost_o high or as a report where lock should have been lost.

// File: rtl/tdma_seq_pkg.sv
package tdma_seq_pkg;
  typedef enum logic [2:0] {
    RG_HDR  = 3'd0,
    RG_VF1  = 3'd1,
    RG_VF2A = 3'd2,
    RG_CTR  = 3'd3,
    RG_VF2B = 3'd4,
    RG_VF3  = 3'd5
  } region_e;
endpackage

// File: rtl/tdma_pos_ctr.sv
module tdma_pos_ctr
  import tdma_seq_pkg::*;
#(
  parameter int HDR_LEN  = 12,
  parameter int VF_LEN   = 36,
  parameter int HALF_LEN = 18,
  parameter int CTR_LEN  = 24,
  parameter int PW       = 8
) (
  input  logic          clk,
  input  logic          clr,
  input  logic          adv,
  output logic [PW-1:0] pos_o,
  output region_e       region_o,
  output logic          last_o
);
  localparam int E1 = HDR_LEN;
  localparam int E2 = E1 + VF_LEN;
  localparam int E3 = E2 + HALF_LEN;
  localparam int E4 = E3 + CTR_LEN;
  localparam int E5 = E4 + HALF_LEN;
  localparam int BLEN = E5 + VF_LEN;

  logic [PW-1:0] pos_q;

  assign last_o = (pos_q == PW'(BLEN - 1));
  assign pos_o  = pos_q;

  always_ff @(posedge clk) begin
    if (clr)      pos_q <= '0;
    else if (adv) pos_q <= last_o ? '0 : pos_q + PW'(1);
  end

  always_comb begin
    if (pos_q < PW'(E1))      region_o = RG_HDR;
    else if (pos_q < PW'(E2)) region_o = RG_VF1;
    else if (pos_q < PW'(E3)) region_o = RG_VF2A;
    else if (pos_q < PW'(E4)) region_o = RG_CTR;
    else if (pos_q < PW'(E5)) region_o = RG_VF2B;
    else                      region_o = RG_VF3;
  end
endmodule

// File: rtl/tdma_ctr_cap.sv
module tdma_ctr_cap #(
  parameter int          CTR_LEN   = 24,
  parameter int          EMB_HALF  = 8,
  parameter logic [23:0] VOICE_PAT = 24'h439B4D,
  parameter logic [23:0] DATA_PAT  = 24'hBC64B2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  shift_i,
  input  logic                  done_i,
  input  logic [1:0]            dibit_i,
  output logic [2*CTR_LEN-1:0]  next_o,
  output logic                  voice_hit_o,
  output logic                  data_hit_o,
  output logic [2*EMB_HALF-1:0] emb_o
);
  localparam int CW = 2 * CTR_LEN;

  logic [CW-1:0]      sh_q;
  logic [CTR_LEN-1:0] sym;

  assign next_o = {sh_q[CW-3:0], dibit_i};

  for (genvar i = 0; i < CTR_LEN; i++) begin : g_sym
    assign sym[i] = next_o[2*i+1];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q        <= '0;
      voice_hit_o <= 1'b0;
      data_hit_o  <= 1'b0;
      emb_o       <= '0;
    end else begin
      if (shift_i) sh_q <= next_o;
      if (done_i) begin
        voice_hit_o <= (sym == VOICE_PAT[CTR_LEN-1:0]);
        data_hit_o  <= (sym == DATA_PAT[CTR_LEN-1:0]);
        emb_o       <= {next_o[CW-1 -: EMB_HALF], next_o[EMB_HALF-1:0]};
      end
    end
  end
endmodule

// File: rtl/tdma_carrier_chk.sv
module tdma_carrier_chk #(
  parameter int PW        = 8,
  parameter int VF1_START = 12,
  parameter int NPOS      = 8,
  parameter int POSN [NPOS] = '{1, 3, 7, 13, 16, 27, 32, 33}
) (
  input  logic          clk,
  input  logic          clr,
  input  logic          adv,
  input  logic [PW-1:0] pos_i,
  input  logic [1:0]    dibit_i,
  input  logic          commit_i,
  output logic          same_o
);
  logic [1:0]      cur_q  [NPOS];
  logic [1:0]      prev_q [NPOS];
  logic [NPOS-1:0] eq;
  logic            have_q;

  for (genvar k = 0; k < NPOS; k++) begin : g_tap
    always_ff @(posedge clk) begin
      if (adv && pos_i == PW'(VF1_START + POSN[k])) cur_q[k] <= dibit_i;
      if (clr)           prev_q[k] <= '0;
      else if (commit_i) prev_q[k] <= cur_q[k];
    end
    assign eq[k] = (cur_q[k] == prev_q[k]);
  end

  always_ff @(posedge clk) begin
    if (clr)           have_q <= 1'b0;
    else if (commit_i) have_q <= 1'b1;
  end

  assign same_o = have_q && (&eq);
endmodule

// File: rtl/tdma_burst_seq.sv
module tdma_burst_seq
  import tdma_seq_pkg::*;
#(
  parameter int          HDR_LEN      = 12,
  parameter int          VF_LEN       = 36,
  parameter int          HALF_LEN     = 18,
  parameter int          CTR_LEN      = 24,
  parameter int          EMB_HALF     = 8,
  parameter int          VC_MAX       = 14,
  parameter int          VC_ENTRY     = 2,
  parameter int          LC_FIRST     = 2,
  parameter int          LC_LAST      = 6,
  parameter int          DATA_RUN_MAX = 2,
  parameter logic [23:0] VOICE_PAT    = 24'h439B4D,
  parameter logic [23:0] DATA_PAT     = 24'hBC64B2,
  parameter int          VCW          = $clog2(VC_MAX + 2)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  restart_i,
  input  logic                  dibit_vld_i,
  input  logic [1:0]            dibit_i,
  input  logic                  tact_ok_i,
  input  logic                  tact_slot_i,
  input  logic                  emb_ok_i,
  output logic                  out_vld_o,
  output logic [2:0]            out_region_o,
  output logic [1:0]            out_dibit_o,
  output logic                  burst_vld_o,
  output logic                  burst_slot_o,
  output logic                  burst_data_o,
  output logic [VCW-1:0]        burst_vc_o,
  output logic                  lc_done_o,
  output logic [2*EMB_HALF-1:0] emb_bits_o,
  output logic [3:0]            cc_o,
  output logic                  pi_o,
  output logic [1:0]            lcss_o,
  output logic                  frag_we_o,
  output logic                  frag_slot_o,
  output logic [VCW-1:0]        frag_idx_o,
  output logic [2*CTR_LEN-1:0]  frag_data_o,
  output logic [VCW-1:0]        cnt0_o,
  output logic [VCW-1:0]        cnt1_o,
  output logic                  lost_o
);
  localparam int BLEN    = HDR_LEN + 2 * VF_LEN + 2 * HALF_LEN + CTR_LEN;
  localparam int PW      = $clog2(BLEN);
  localparam int CTR_END = HDR_LEN + VF_LEN + HALF_LEN + CTR_LEN - 1;
  localparam int RW      = $clog2(DATA_RUN_MAX + 2);
  localparam int EW      = 2 * EMB_HALF;

  logic [PW-1:0]        pos;
  region_e              region;
  logic                 pos_last, adv, last, clr;
  logic [2*CTR_LEN-1:0] ctr_next;
  logic                 voice_hit, data_hit, same;
  logic [EW-1:0]        emb;
  logic                 tact_ok_q, slot_q;
  logic [VCW-1:0]       cnt_q [2];
  logic [RW-1:0]        run_q, run_n;
  logic [VCW-1:0]       cur_c, vc_n, step;
  logic                 lose_n;

  assign adv  = dibit_vld_i && !lost_o;
  assign last = adv && pos_last;
  assign clr  = rst || restart_i;

  tdma_pos_ctr #(
    .HDR_LEN(HDR_LEN), .VF_LEN(VF_LEN), .HALF_LEN(HALF_LEN),
    .CTR_LEN(CTR_LEN), .PW(PW)
  ) pos_i (
    .clk(clk), .clr(clr), .adv(adv),
    .pos_o(pos), .region_o(region), .last_o(pos_last)
  );

  tdma_ctr_cap #(
    .CTR_LEN(CTR_LEN), .EMB_HALF(EMB_HALF),
    .VOICE_PAT(VOICE_PAT), .DATA_PAT(DATA_PAT)
  ) cap_i (
    .clk(clk), .rst(rst),
    .shift_i(adv && region == RG_CTR),
    .done_i(adv && pos == PW'(CTR_END)),
    .dibit_i(dibit_i), .next_o(ctr_next),
    .voice_hit_o(voice_hit), .data_hit_o(data_hit), .emb_o(emb)
  );

  tdma_carrier_chk #(
    .PW(PW), .VF1_START(HDR_LEN)
  ) car_i (
    .clk(clk), .clr(clr || (last && lose_n)), .adv(adv),
    .pos_i(pos), .dibit_i(dibit_i),
    .commit_i(last && !lose_n), .same_o(same)
  );

  // end-of-burst decision, in priority order
  always_comb begin
    cur_c  = cnt_q[slot_q];
    vc_n   = voice_hit ? VCW'(1) : cur_c;
    step   = vc_n + VCW'(1);
    run_n  = run_q + RW'(1);
    lose_n = 1'b0;
    if (!tact_ok_q)                   lose_n = 1'b1;
    else if (same)                    lose_n = 1'b1;
    else if (data_hit)                lose_n = (run_n > RW'(DATA_RUN_MAX));
    else if (!voice_hit && !emb_ok_i) lose_n = 1'b1;
    else if (step > VCW'(VC_MAX))     lose_n = 1'b1;
  end

  assign cnt0_o     = cnt_q[0];
  assign cnt1_o     = cnt_q[1];
  assign emb_bits_o = emb;

  always_ff @(posedge clk) begin
    if (clr) begin
      lost_o       <= 1'b0;
      cnt_q[0]     <= VCW'(VC_ENTRY);
      cnt_q[1]     <= VCW'(VC_ENTRY);
      run_q        <= '0;
      tact_ok_q    <= 1'b0;
      slot_q       <= 1'b0;
      out_vld_o    <= 1'b0;
      out_region_o <= '0;
      out_dibit_o  <= '0;
      burst_vld_o  <= 1'b0;
      burst_slot_o <= 1'b0;
      burst_data_o <= 1'b0;
      burst_vc_o   <= '0;
      lc_done_o    <= 1'b0;
      cc_o         <= '0;
      pi_o         <= 1'b0;
      lcss_o       <= '0;
      frag_we_o    <= 1'b0;
      frag_slot_o  <= 1'b0;
      frag_idx_o   <= '0;
      frag_data_o  <= '0;
    end else begin
      out_vld_o   <= adv;
      burst_vld_o <= 1'b0;
      lc_done_o   <= 1'b0;
      frag_we_o   <= 1'b0;
      if (adv) begin
        out_region_o <= region;
        out_dibit_o  <= dibit_i;
      end
      if (adv && pos == PW'(HDR_LEN - 1)) begin
        tact_ok_q <= tact_ok_i;
        slot_q    <= tact_slot_i;
      end
      if (adv && pos == PW'(CTR_END) &&
          cnt_q[slot_q] >= VCW'(LC_FIRST) && cnt_q[slot_q] <= VCW'(LC_LAST)) begin
        frag_we_o   <= 1'b1;
        frag_slot_o <= slot_q;
        frag_idx_o  <= cnt_q[slot_q];
        frag_data_o <= ctr_next;
      end
      if (last) begin
        if (lose_n) begin
          lost_o   <= 1'b1;
          cnt_q[0] <= VCW'(VC_ENTRY);
          cnt_q[1] <= VCW'(VC_ENTRY);
          run_q    <= '0;
        end else begin
          burst_vld_o  <= 1'b1;
          burst_slot_o <= slot_q;
          burst_data_o <= data_hit;
          if (data_hit) begin
            cnt_q[slot_q] <= VCW'(1);
            run_q         <= run_n;
            burst_vc_o    <= '0;
          end else begin
            cnt_q[slot_q] <= step;
            run_q         <= '0;
            burst_vc_o    <= vc_n;
            lc_done_o     <= (vc_n == VCW'(LC_LAST));
            if (emb_ok_i) begin
              cc_o   <= emb[EW-1 -: 4];
              pi_o   <= emb[EW-5];
              lcss_o <= emb[EW-6 -: 2];
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/tdma_burst_seq_chk.sv
module tdma_burst_seq_chk #(
  parameter int VC_MAX   = 14,
  parameter int LC_FIRST = 2,
  parameter int LC_LAST  = 6,
  parameter int VCW      = 4
) (
  input logic           clk,
  input logic           rst,
  input logic           restart_i,
  input logic           out_vld_o,
  input logic [2:0]     out_region_o,
  input logic           burst_vld_o,
  input logic           burst_slot_o,
  input logic           burst_data_o,
  input logic [VCW-1:0] burst_vc_o,
  input logic           lc_done_o,
  input logic           frag_we_o,
  input logic [VCW-1:0] frag_idx_o,
  input logic [VCW-1:0] cnt0_o,
  input logic [VCW-1:0] cnt1_o,
  input logic           lost_o
);
  logic [VCW-1:0] rep_cnt;
  assign rep_cnt = burst_slot_o ? cnt1_o : cnt0_o;

  assert_region_range_R1: assert property (@(posedge clk) disable iff (rst)
    out_vld_o |-> out_region_o <= 3'd5);

  assert_data_count_R4: assert property (@(posedge clk) disable iff (rst)
    (burst_vld_o && burst_data_o) |-> rep_cnt == VCW'(1));

  assert_voice_count_R4: assert property (@(posedge clk) disable iff (rst)
    (burst_vld_o && !burst_data_o) |-> rep_cnt == burst_vc_o + VCW'(1));

  assert_frag_window_R5: assert property (@(posedge clk) disable iff (rst)
    frag_we_o |-> (frag_idx_o >= VCW'(LC_FIRST) && frag_idx_o <= VCW'(LC_LAST)));

  assert_lc_on_sixth_R6: assert property (@(posedge clk) disable iff (rst)
    lc_done_o |-> (burst_vld_o && !burst_data_o && burst_vc_o == VCW'(LC_LAST)));

  assert_count_limit_R8: assert property (@(posedge clk) disable iff (rst)
    (cnt0_o >= VCW'(1) && cnt0_o <= VCW'(VC_MAX) &&
     cnt1_o >= VCW'(1) && cnt1_o <= VCW'(VC_MAX)));

  assert_lost_sticky_R12: assert property (@(posedge clk) disable iff (rst)
    (lost_o && !restart_i) |=> lost_o);

  assert_lost_quiet_R12: assert property (@(posedge clk) disable iff (rst)
    lost_o |=> (!out_vld_o && !burst_vld_o));
endmodule

bind tdma_burst_seq tdma_burst_seq_chk #(
  .VC_MAX(VC_MAX), .LC_FIRST(LC_FIRST), .LC_LAST(LC_LAST), .VCW(VCW)
) chk_i (.*);

// File: tb/tdma_burst_seq_tb_top.sv
module tdma_burst_seq_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic restart_i = 1'b0;
  logic dibit_vld_i = 1'b0;
  logic [1:0] dibit_i = '0;
  logic tact_ok_i = 1'b1, tact_slot_i = 1'b0, emb_ok_i = 1'b0;
  logic out_vld_o, burst_vld_o, burst_slot_o, burst_data_o, lc_done_o;
  logic [2:0] out_region_o;
  logic [1:0] out_dibit_o, lcss_o;
  logic [3:0] burst_vc_o, cc_o, frag_idx_o, cnt0_o, cnt1_o;
  logic [15:0] emb_bits_o;
  logic pi_o, frag_we_o, frag_slot_o, lost_o;
  logic [47:0] frag_data_o;

  always #5 clk = ~clk;

  tdma_burst_seq dut_i (.*);

  localparam logic [23:0] VP = 24'h439B4D;
  localparam logic [23:0] DP = 24'hBC64B2;

  typedef struct packed {
    logic slot; logic [1:0] bt; logic eok; logic [15:0] emb;
    logic dat; logic [3:0] vc; logic lc; logic [3:0] frag;
    logic [3:0] c0; logic [3:0] c1;
  } vec_t;

  // bt: 0 embedded signalling, 1 voice sync, 2 data sync
  localparam vec_t TBL [15] = '{
    '{1'b0, 2'd1, 1'b0, 16'h0000, 1'b0, 4'd1, 1'b0, 4'd2, 4'd2, 4'd2},
    '{1'b1, 2'd1, 1'b0, 16'h0000, 1'b0, 4'd1, 1'b0, 4'd2, 4'd2, 4'd2},
    '{1'b0, 2'd0, 1'b1, 16'h9A41, 1'b0, 4'd2, 1'b0, 4'd2, 4'd3, 4'd2},
    '{1'b1, 2'd0, 1'b1, 16'h3C82, 1'b0, 4'd2, 1'b0, 4'd2, 4'd3, 4'd3},
    '{1'b0, 2'd0, 1'b1, 16'h5613, 1'b0, 4'd3, 1'b0, 4'd3, 4'd4, 4'd3},
    '{1'b1, 2'd0, 1'b1, 16'hE7A4, 1'b0, 4'd3, 1'b0, 4'd3, 4'd4, 4'd4},
    '{1'b0, 2'd0, 1'b1, 16'h1B25, 1'b0, 4'd4, 1'b0, 4'd4, 4'd5, 4'd4},
    '{1'b1, 2'd0, 1'b1, 16'h8C66, 1'b0, 4'd4, 1'b0, 4'd4, 4'd5, 4'd5},
    '{1'b0, 2'd0, 1'b1, 16'h2D07, 1'b0, 4'd5, 1'b0, 4'd5, 4'd6, 4'd5},
    '{1'b1, 2'd0, 1'b1, 16'hF0C8, 1'b0, 4'd5, 1'b0, 4'd5, 4'd6, 4'd6},
    '{1'b0, 2'd0, 1'b1, 16'h4E19, 1'b0, 4'd6, 1'b1, 4'd6, 4'd7, 4'd6},
    '{1'b1, 2'd0, 1'b1, 16'h7B2A, 1'b0, 4'd6, 1'b1, 4'd6, 4'd7, 4'd7},
    '{1'b0, 2'd2, 1'b0, 16'h0000, 1'b1, 4'd0, 1'b0, 4'd0, 4'd1, 4'd7},
    '{1'b1, 2'd1, 1'b0, 16'h0000, 1'b0, 4'd1, 1'b0, 4'd0, 4'd1, 4'd2},
    '{1'b0, 2'd0, 1'b1, 16'hA55B, 1'b0, 4'd1, 1'b0, 4'd0, 4'd2, 4'd2}
  };

  int checks = 0, fails = 0;
  int seed = 0;
  logic frag_seen, any_out, chk_layout;
  logic [3:0] frag_idx_seen;
  logic [47:0] frag_data_seen;
  bit done = 0;

  task automatic chk(input logic ok, input string req, input logic [47:0] act, input logic [47:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [2:0] exp_region(input int p);
    if (p < 12) return 3'd0;
    if (p < 48) return 3'd1;
    if (p < 66) return 3'd2;
    if (p < 90) return 3'd3;
    if (p < 108) return 3'd4;
    return 3'd5;
  endfunction

  function automatic logic [1:0] gen(input int i, input logic [1:0] bt, input logic [15:0] emb, input int sd);
    logic [47:0] c;
    int j;
    c = {emb[15:8], 32'h0, emb[7:0]};
    if (i >= 12 && i < 48) return 2'((sd + i) & 3);
    if (i >= 66 && i < 90) begin
      j = i - 66;
      if (bt == 2'd1) return {VP[23-j], 1'b1};
      if (bt == 2'd2) return {DP[23-j], 1'b1};
      return c[47-2*j -: 2];
    end
    return 2'(i & 3);
  endfunction

  // sends one burst; returns at the negedge where the end-of-burst report is visible
  task automatic send_burst(input logic slot, input logic tok, input logic [1:0] bt,
                            input logic [15:0] emb, input logic eok, input int sd);
    frag_seen = 0; any_out = 0;
    tact_ok_i = tok; tact_slot_i = slot; emb_ok_i = eok;
    for (int i = 0; i < 144; i++) begin
      @(negedge clk);
      if (out_vld_o) any_out = 1;
      if (frag_we_o) begin frag_seen = 1; frag_idx_seen = frag_idx_o; frag_data_seen = frag_data_o; end
      if (chk_layout && i > 0 && (exp_region(i-1) != exp_region(i) || i == 1)) begin
        chk(out_vld_o && out_region_o == exp_region(i-1), "R1 region", 48'(out_region_o), 48'(exp_region(i-1)));
        chk(out_dibit_o == gen(i-1, bt, emb, sd), "R1 echo", 48'(out_dibit_o), 48'(gen(i-1, bt, emb, sd)));
      end
      dibit_vld_i = 1'b1;
      dibit_i = gen(i, bt, emb, sd);
    end
    @(negedge clk);
    if (out_vld_o) any_out = 1;
    dibit_vld_i = 1'b0;
  endtask

  task automatic do_restart();
    @(negedge clk); restart_i = 1'b1;
    @(negedge clk); restart_i = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    chk_layout = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    // R12 reset state
    chk(!lost_o, "R12 reset lost", 48'(lost_o), 0);
    chk(cnt0_o == 4'd2 && cnt1_o == 4'd2, "R12 reset counters", {cnt0_o, cnt1_o}, 48'h22);
    chk(!burst_vld_o && !out_vld_o, "R12 reset strobes", {burst_vld_o, out_vld_o}, 0);

    for (int r = 0; r < 15; r++) begin
      vec_t v;
      v = TBL[r];
      chk_layout = (r == 0);
      seed++;
      send_burst(v.slot, 1'b1, v.bt, v.emb, v.eok, seed);
      chk(!lost_o, "R7 lock kept", 48'(lost_o), 0);
      chk(burst_vld_o && burst_slot_o == v.slot, "R4 report/slot", {burst_vld_o, burst_slot_o}, {1'b1, v.slot});
      chk(burst_data_o == v.dat, "R2 sync class", 48'(burst_data_o), 48'(v.dat));
      chk(burst_vc_o == v.vc, "R4 vc", 48'(burst_vc_o), 48'(v.vc));
      chk(cnt0_o == v.c0 && cnt1_o == v.c1, "R4 counters", {cnt0_o, cnt1_o}, {v.c0, v.c1});
      chk(lc_done_o == v.lc, "R6 lc done", 48'(lc_done_o), 48'(v.lc));
      chk((frag_seen ? frag_idx_seen : 4'd0) == v.frag, "R5 fragment index",
          48'(frag_seen ? frag_idx_seen : 4'd0), 48'(v.frag));
      if (v.eok) begin
        chk(emb_bits_o == v.emb, "R3 emb bits", 48'(emb_bits_o), 48'(v.emb));
        chk({cc_o, pi_o, lcss_o} == v.emb[15:9], "R3 fields", 48'({cc_o, pi_o, lcss_o}), 48'(v.emb[15:9]));
      end
      if (r == 2)
        chk(frag_data_seen == {v.emb[15:8], 32'h0, v.emb[7:0]}, "R5 fragment data",
            frag_data_seen, {v.emb[15:8], 32'h0, v.emb[7:0]});
    end
    chk_layout = 0;

    // R8 counter limit on slot 0 (counter is 2 here)
    for (int k = 0; k < 12; k++) begin seed++; send_burst(1'b0, 1'b1, 2'd0, 16'h1234, 1'b1, seed); end
    chk(!lost_o && cnt0_o == 4'd14, "R8 at limit", {lost_o, cnt0_o}, 48'h0E);
    seed++; send_burst(1'b0, 1'b1, 2'd0, 16'h1234, 1'b1, seed);
    chk(lost_o && !burst_vld_o, "R8 over limit", {lost_o, burst_vld_o}, 48'h2);
    chk(cnt0_o == 4'd2 && cnt1_o == 4'd2, "R12 counters cleared", {cnt0_o, cnt1_o}, 48'h22);
    // R12 dibits ignored while lost
    seed++; send_burst(1'b0, 1'b1, 2'd1, 16'h0, 1'b0, seed);
    chk(!any_out && !burst_vld_o && lost_o, "R12 ignored while lost", {any_out, burst_vld_o, lost_o}, 48'h1);
    do_restart();
    chk(!lost_o, "R12 restart", 48'(lost_o), 0);

    // R9 data run
    seed++; send_burst(1'b0, 1'b1, 2'd2, 16'h0, 1'b0, seed);
    seed++; send_burst(1'b1, 1'b1, 2'd2, 16'h0, 1'b0, seed);
    seed++; send_burst(1'b1, 1'b1, 2'd1, 16'h0, 1'b0, seed);
    seed++; send_burst(1'b0, 1'b1, 2'd2, 16'h0, 1'b0, seed);
    seed++; send_burst(1'b1, 1'b1, 2'd2, 16'h0, 1'b0, seed);
    chk(!lost_o && burst_vld_o, "R9 voice clears run", {lost_o, burst_vld_o}, 48'h1);
    seed++; send_burst(1'b0, 1'b1, 2'd2, 16'h0, 1'b0, seed);
    chk(lost_o && !burst_vld_o, "R9 third data burst", {lost_o, burst_vld_o}, 48'h2);
    do_restart();

    // R7 embedded check failure on non-sync burst
    seed++; send_burst(1'b0, 1'b1, 2'd0, 16'h4321, 1'b0, seed);
    chk(lost_o && !burst_vld_o, "R7 emb fail", {lost_o, burst_vld_o}, 48'h2);
    do_restart();

    // R11 header failure
    seed++; send_burst(1'b1, 1'b0, 2'd1, 16'h0, 1'b0, seed);
    chk(lost_o && !burst_vld_o, "R11 header fail", {lost_o, burst_vld_o}, 48'h2);
    do_restart();

    // R10 frozen voice frame one
    seed++; send_burst(1'b0, 1'b1, 2'd1, 16'h0, 1'b0, seed);
    chk(!lost_o && burst_vld_o, "R10 first burst no history", {lost_o, burst_vld_o}, 48'h1);
    send_burst(1'b1, 1'b1, 2'd0, 16'h6789, 1'b1, seed);
    chk(lost_o && !burst_vld_o, "R10 carrier loss", {lost_o, burst_vld_o}, 48'h2);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule